// File: doc/BRIEF.md
# Eight-Bit Arithmetic-Logic Unit with Status Flags

A purely combinational 8-bit arithmetic-logic unit. Two 8-bit operands and a 4-bit operation code go in. An 8-bit result and four status flags come out: zero, negative, carry and signed overflow. Every arithmetic operation runs through a single 8-bit ripple chain of full adders. The operands and the carry-in for that chain are chosen by the operation code.

Two enable outputs go to the surrounding datapath. `res_wr` tells the register file whether to store the result. `flg_wr` tells the flag register whether to load the new flags. Compare drives the flags but suppresses the result write. The no-op operation suppresses both writes.

Top module: `alu8_flags`

## Requirements
- R1: Arithmetic codes, with the result taken modulo 256:
  - 0x0 adds A+B.
  - 0x1 subtracts A-B.
  - 0x8 increments A.
  - 0x9 decrements A.
  - 0xB negates A, giving 0-A.
- R2: Logic, shift and constant codes:
  - 0x2 gives A&B, 0x3 gives A|B, 0x4 gives A^B and 0x5 gives ~A.
  - 0x6 shifts A left by one, filling with 0.
  - 0x7 shifts A right by one, logically, filling with 0.
  - 0xC passes A through.
  - 0xD gives 0x00 and 0xE gives 0xFF.
- R3: `flg_z` is 1 exactly when the 8-bit result is 0x00.
- R4: `flg_n` equals bit 7 of the result.
- R5: `flg_c` depends on the code:
  - Add and increment: the carry out of bit 7.
  - Subtract, compare, decrement and negate: 1 when no borrow occurs (A>=B, A!=0 and A==0 respectively).
  - Shift left: bit 7 of A. Shift right: bit 0 of A.
  - Every other code: 0.
- R6: `flg_v` is 1 when the two adder inputs share a sign and the sum's sign differs. This gives increment 0x7F, decrement 0x80 and negate 0x80 as the overflow cases. It is 0 for every logic, shift and constant code.
- R7: Compare (0xA) computes A-B, sets the flags as subtract does, drives `res_wr`=0 and `flg_wr`=1.
- R8: No-op (0xF) drives `res_wr`=0, `flg_wr`=0 and a result of 0x00.
- R9: Every code other than 0xA and 0xF drives `res_wr`=1 and `flg_wr`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| op_code | input | 4 | Operation select |
| res | output | 8 | Result |
| flg_z | output | 1 | Zero flag |
| flg_n | output | 1 | Negative flag |
| flg_c | output | 1 | Carry / no-borrow flag |
| flg_v | output | 1 | Signed overflow flag |
| res_wr | output | 1 | Result write enable |
| flg_wr | output | 1 | Flag write enable |

## Verification
Uniform random operands over all sixteen codes cover the general result and flag paths. They rarely reach the edges, so a directed set adds them:
- Operands 0x00, 0x7F, 0x80 and 0xFF, paired with one another. These separate correct signed overflow from an unsigned-only check, and no-borrow carry from a plain borrow bit.
- Equal operands, which show whether compare and subtract set zero and carry together.
- Single-bit operands on the shifts, which expose a swapped carry source or the wrong fill bit.
- The compare and no-op codes, which tell the two write enables apart.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   op_code,
  output logic [W-1:0] res,
  output logic         flg_z,
  output logic         flg_n,
  output logic         flg_c,
  output logic         flg_v,
  output logic         res_wr,
  output logic         flg_wr
);
  localparam logic [3:0] C_ADD = 4'h0, C_SUB = 4'h1, C_AND = 4'h2, C_OR = 4'h3,
                         C_XOR = 4'h4, C_NOT = 4'h5, C_SHL = 4'h6, C_SHR = 4'h7,
                         C_INC = 4'h8, C_DEC = 4'h9, C_CMP = 4'hA, C_NEG = 4'hB,
                         C_PAS = 4'hC, C_ZER = 4'hD, C_ONE = 4'hE, C_NOP = 4'hF;

  logic [W-1:0] ax, by, sum;
  logic         cin;
  logic [W:0]   cy;
  logic         arith;

  always_comb begin
    ax  = op_a;
    by  = op_b;
    cin = 1'b0;
    unique case (op_code)
      C_SUB, C_CMP: begin by = ~op_b; cin = 1'b1; end
      C_INC:        begin by = '0;    cin = 1'b1; end
      C_DEC:        begin by = '1;    cin = 1'b0; end
      C_NEG:        begin ax = '0; by = ~op_a; cin = 1'b1; end
      default: ;
    endcase
  end

  assign cy[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = ax[i] ^ by[i] ^ cy[i];
    assign cy[i+1] = (ax[i] & by[i]) | (cy[i] & (ax[i] ^ by[i]));
  end

  assign arith = (op_code == C_ADD) || (op_code == C_SUB) || (op_code == C_INC) ||
                 (op_code == C_DEC) || (op_code == C_CMP) || (op_code == C_NEG);

  always_comb begin
    unique case (op_code)
      C_AND:   res = op_a & op_b;
      C_OR:    res = op_a | op_b;
      C_XOR:   res = op_a ^ op_b;
      C_NOT:   res = ~op_a;
      C_SHL:   res = {op_a[W-2:0], 1'b0};
      C_SHR:   res = {1'b0, op_a[W-1:1]};
      C_PAS:   res = op_a;
      C_ZER:   res = '0;
      C_ONE:   res = '1;
      C_NOP:   res = '0;
      default: res = sum;
    endcase
  end

  always_comb begin
    unique case (op_code)
      C_SHL:   flg_c = op_a[W-1];
      C_SHR:   flg_c = op_a[0];
      default: flg_c = arith & cy[W];
    endcase
  end

  assign flg_v  = arith & (ax[W-1] == by[W-1]) & (sum[W-1] != ax[W-1]);
  assign flg_z  = (res == '0);
  assign flg_n  = res[W-1];
  assign res_wr = (op_code != C_CMP) && (op_code != C_NOP);
  assign flg_wr = (op_code != C_NOP);
endmodule

module alu8_flags_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [3:0]   op_code,
  input logic [W-1:0] res,
  input logic         flg_z,
  input logic         flg_n,
  input logic         flg_c,
  input logic         flg_v,
  input logic         res_wr,
  input logic         flg_wr
);
  always_comb begin
    if (op_code == 4'hA) AST_CMP_NO_RESULT: assert (!res_wr && flg_wr); // R7
    if (op_code == 4'hF) AST_NOP_NO_WRITE: assert (!res_wr && !flg_wr && res == '0); // R8
    if (op_code inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hC, 4'hD, 4'hE})
      AST_NO_OVERFLOW: assert (!flg_v); // R6
    if (op_code == 4'h1) AST_SUB_NO_BORROW: assert (flg_c == (op_a >= op_b)); // R5
    if (op_code == 4'hD) AST_ZERO_CONST: assert (flg_z && !flg_n); // R3
    if (op_code == 4'hE) AST_ONES_CONST: assert (flg_n && !flg_z); // R4
  end
endmodule

bind alu8_flags alu8_flags_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst = 1;
  logic [7:0] a, b, r;
  logic [3:0] op;
  logic z, n, c, v, rw, fw;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] e_r;
  logic e_c, e_v, e_rw, e_fw;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flags u0 (.op_a(a), .op_b(b), .op_code(op), .res(r), .flg_z(z), .flg_n(n),
                 .flg_c(c), .flg_v(v), .res_wr(rw), .flg_wr(fw));

  function automatic bit ovf(int s);
    return (s > 127) || (s < -128);
  endfunction

  task automatic model(input logic [7:0] x, input logic [7:0] y, input logic [3:0] o);
    int sx = $signed(x), sy = $signed(y);
    int ux = x, uy = y;
    e_c = 0; e_v = 0; e_rw = (o != 4'hA) && (o != 4'hF); e_fw = (o != 4'hF);
    case (o)
      4'h0: begin e_r = 8'(ux + uy); e_c = (ux + uy) > 255; e_v = ovf(sx + sy); end
      4'h1, 4'hA: begin e_r = 8'(ux - uy); e_c = ux >= uy; e_v = ovf(sx - sy); end
      4'h2: e_r = x & y;
      4'h3: e_r = x | y;
      4'h4: e_r = x ^ y;
      4'h5: e_r = ~x;
      4'h6: begin e_r = 8'(ux * 2); e_c = x[7]; end
      4'h7: begin e_r = 8'(ux / 2); e_c = x[0]; end
      4'h8: begin e_r = 8'(ux + 1); e_c = (ux == 255); e_v = ovf(sx + 1); end
      4'h9: begin e_r = 8'(ux - 1); e_c = (ux != 0); e_v = ovf(sx - 1); end
      4'hB: begin e_r = 8'(0 - ux); e_c = (ux == 0); e_v = ovf(0 - sx); end
      4'hC: e_r = x;
      4'hD: e_r = 8'h00;
      4'hE: e_r = 8'hFF;
      default: e_r = 8'h00;
    endcase
  endtask

  task automatic chk(input string tag, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s op=%h a=%h b=%h actual=%0h expected=%0h", tag, op, a, b, act, exp_v);
    end
  endtask

  task automatic apply(input logic [7:0] x, input logic [7:0] y, input logic [3:0] o);
    @(negedge clk);
    a = x; b = y; op = o;
    #1;
    model(x, y, o);
    if (o inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hB}) chk("R1 result", r, e_r);
    else if (o == 4'hA) chk("R7 cmp result", r, e_r);
    else if (o == 4'hF) chk("R8 nop result", r, e_r);
    else chk("R2 result", r, e_r);
    chk("R3 zero", z, e_r == 0);
    chk("R4 negative", n, e_r[7]);
    chk("R5 carry", c, e_c);
    chk("R6 overflow", v, e_v);
    if (o == 4'hA) begin chk("R7 res_wr", rw, 0); chk("R7 flg_wr", fw, 1); end
    else if (o == 4'hF) begin chk("R8 res_wr", rw, 0); chk("R8 flg_wr", fw, 0); end
    else begin chk("R9 res_wr", rw, e_rw); chk("R9 flg_wr", fw, e_fw); end
  endtask

  initial begin
    logic [7:0] edge_v [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    void'($urandom(32'h1234_5678));
    a = 0; b = 0; op = 4'hF;
    repeat (2) @(posedge clk);
    #1;
    chk("R8 reset-state res_wr", rw, 0);
    chk("R8 reset-state flg_wr", fw, 0);
    rst = 0;
    for (int o = 0; o < 16; o++)
      foreach (edge_v[i]) foreach (edge_v[j]) apply(edge_v[i], edge_v[j], 4'(o));
    for (int o = 0; o < 16; o++) apply(8'h5A, 8'h5A, 4'(o));
    for (int k = 0; k < 8; k++) begin
      apply(8'(1 << k), 8'h00, 4'h6);
      apply(8'(1 << k), 8'h00, 4'h7);
    end
    for (int k = 0; k < 4000; k++) apply(8'($urandom), 8'($urandom), 4'($urandom));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule